// File: doc/BRIEF.md
# Code Memory Lock Guard

This block turns the three non-volatile lock bits of a small 8-bit controller into one of four stacked protection levels and uses that level to answer every access request aimed at the on-chip code memory. Each level keeps all the restrictions of the level below it and adds one more. At the lowest level nothing is refused. At the top level internal-code table reads started from external code, programming, read-back verify and execution from external code are all refused.

Requesters raise one strobe bit per access type. One clock later the block answers each strobed bit with either a grant pulse or a deny pulse. Once any lock bit is programmed, the external-access pin level is captured only while reset is held. The captured value is kept until the next reset. A flag is raised when the captured value no longer matches the live pin.

Top module: `code_lock_guard`

## Requirements
- R1: `lock_bits_i` bit 0 is the first lock bit, bit 1 the second and bit 2 the third, with 1 meaning programmed. Code 000 selects level 1, 001 level 2, 011 level 3 and 111 level 4. Each of the other four codes is treated as level 4.
- R2: At level 1 every strobed request is granted.
- R3: At level 2 and above, a table read from external code into internal memory (`req_i` bit 1) and a program request (bit 2) are denied.
- R4: At level 3 and above, a verify request (`req_i` bit 3) is denied.
- R5: At level 4, a request to execute from external code (`req_i` bit 4) is denied. Below level 4 it is granted.
- R6: An internal code fetch (`req_i` bit 0) is granted at every level.
- R7: For each bit strobed in `req_i` in one cycle, exactly one of `grant_o` and `deny_o` goes high in that bit on the next cycle. Bits that were not strobed stay low in both outputs.
- R8: While `rst_ni` is low, `grant_o`, `deny_o` and `ea_mismatch_o` are 0, and `ea_latched_o` takes the pin level on every clock.
- R9: At level 2 and above, once reset is released, `ea_latched_o` keeps the value captured in the last reset cycle, whatever the pin does.
- R10: At level 1, `ea_latched_o` follows `ea_pin_i` with a delay of one clock.
- R11: `ea_mismatch_o` goes high one clock after a cycle in which the level is 2 or above and `ea_latched_o` differs from `ea_pin_i`. It is low one clock after any level-1 cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset; the pin is captured while it is low |
| lock_bits_i | input | 3 | Lock bit values, 1 = programmed |
| ea_pin_i | input | 1 | Live external-access pin level |
| req_i | input | 5 | Request strobes: 0 internal fetch, 1 external table read, 2 program, 3 verify, 4 external execute |
| grant_o | output | 5 | Registered grant pulse per request bit |
| deny_o | output | 5 | Registered deny pulse per request bit |
| ea_latched_o | output | 1 | Captured external-access value |
| ea_mismatch_o | output | 1 | Captured value differs from the live pin while locked |

## Verification
The bench drives every one of the eight lock codes against every one of the 32 request patterns. This catches a decoder that gives an illegal code a weak level or breaks the stacking of levels, for example by letting verify through at level 4. A design that answers unstrobed bits, or answers a strobed bit with both grant and deny, fails the check on the all-zero pattern and on the mixed patterns. The pin is then toggled after reset while the block is locked. A latch that keeps sampling would follow the pin, and a flag that is wired to the wrong condition would stay low. Finally the block returns to level 1, where the latch must resume tracking the pin and the flag must clear.

// File: rtl/lockg_pkg.sv
package lockg_pkg;

   localparam int unsigned LOCK_W = 3;
   localparam int unsigned NREQ   = 5;

   typedef enum logic [1:0] {
      LVL_OPEN     = 2'd0,
      LVL_NOWRITE  = 2'd1,
      LVL_NOVERIFY = 2'd2,
      LVL_NOEXT    = 2'd3
   } lock_level_e;

   localparam int unsigned RQ_FETCH_INT = 0;
   localparam int unsigned RQ_TBL_EXT   = 1;
   localparam int unsigned RQ_PROG      = 2;
   localparam int unsigned RQ_VERIFY    = 3;
   localparam int unsigned RQ_EXT_EXEC  = 4;

   // Lowest level (ordinal 0..3) at which a request is refused; 4 = never.
   function automatic int unsigned deny_from(input int unsigned idx);
      case (idx)
         RQ_TBL_EXT:  return 1;
         RQ_PROG:     return 1;
         RQ_VERIFY:   return 2;
         RQ_EXT_EXEC: return 3;
         default:     return 4;
      endcase
   endfunction

endpackage

// File: rtl/lockg_level_decode.sv
module lockg_level_decode
   import lockg_pkg::*;
(
   input  logic [LOCK_W-1:0] lock_bits_i,
   output lock_level_e       level_o,
   output logic              locked_o
);

   always_comb begin
      unique case (lock_bits_i)
         3'b000:  level_o = LVL_OPEN;
         3'b001:  level_o = LVL_NOWRITE;
         3'b011:  level_o = LVL_NOVERIFY;
         default: level_o = LVL_NOEXT;   // 111 and every illegal code
      endcase
   end

   assign locked_o = (level_o != LVL_OPEN);

   always_comb begin
      if (lock_bits_i == '0)
         AST_OPEN_ONLY_BLANK: assert (level_o == LVL_OPEN);   // R1
   end

endmodule

// File: rtl/lockg_req_gate.sv
module lockg_req_gate
   import lockg_pkg::*;
#(
   parameter int unsigned DENY_FROM = 4
)(
   input  logic        clk_i,
   input  logic        rst_ni,
   input  lock_level_e level_i,
   input  logic        req_i,
   output logic        grant_o,
   output logic        deny_o
);

   localparam logic [2:0] THRESH = 3'(DENY_FROM);

   logic refuse;
   assign refuse = ({1'b0, level_i} >= THRESH);

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         grant_o <= 1'b0;
         deny_o  <= 1'b0;
      end else begin
         grant_o <= req_i & ~refuse;
         deny_o  <= req_i &  refuse;
      end
   end

   AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !req_i |=> (!grant_o && !deny_o));   // R7

endmodule

// File: rtl/lockg_ea_latch.sv
module lockg_ea_latch (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic locked_i,
   input  logic pin_i,
   output logic ea_q_o,
   output logic mismatch_o
);

   // The capture register has no reset value: it is loaded while reset is held.
   always_ff @(posedge clk_i) begin
      if (!rst_ni || !locked_i)
         ea_q_o <= pin_i;
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni)
         mismatch_o <= 1'b0;
      else
         mismatch_o <= locked_i && (ea_q_o != pin_i);
   end

   AST_LATCH_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(rst_ni) && $past(locked_i)) |-> $stable(ea_q_o));   // R9

   AST_MISMATCH_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (locked_i && (ea_q_o != pin_i)) |=> mismatch_o);   // R11

   AST_MISMATCH_OPEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !locked_i |=> !mismatch_o);   // R11

endmodule

// File: rtl/code_lock_guard.sv
module code_lock_guard
   import lockg_pkg::*;
(
   input  logic            clk_i,
   input  logic            rst_ni,
   input  logic [2:0]      lock_bits_i,
   input  logic            ea_pin_i,
   input  logic [4:0]      req_i,
   output logic [4:0]      grant_o,
   output logic [4:0]      deny_o,
   output logic            ea_latched_o,
   output logic            ea_mismatch_o
);

   if (LOCK_W != 3 || NREQ != 5) begin : g_bad_cfg
      $error("code_lock_guard: port widths assume three lock bits and five requests");
   end

   lock_level_e level;
   logic        locked;

   lockg_level_decode u_dec (
      .lock_bits_i (lock_bits_i),
      .level_o     (level),
      .locked_o    (locked)
   );

   for (genvar k = 0; k < NREQ; k++) begin : g_gate
      lockg_req_gate #(.DENY_FROM(deny_from(k))) u_gate (
         .clk_i   (clk_i),
         .rst_ni  (rst_ni),
         .level_i (level),
         .req_i   (req_i[k]),
         .grant_o (grant_o[k]),
         .deny_o  (deny_o[k])
      );
   end

   lockg_ea_latch u_ea (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .locked_i   (locked),
      .pin_i      (ea_pin_i),
      .ea_q_o     (ea_latched_o),
      .mismatch_o (ea_mismatch_o)
   );

   AST_ONE_ANSWER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_i != '0) |=> ((grant_o ^ deny_o) == $past(req_i)));   // R7

   AST_PROG_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_bits_i != 3'b000 && req_i[RQ_PROG]) |=> deny_o[RQ_PROG]);   // R3

   AST_VERIFY_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_bits_i[1] && req_i[RQ_VERIFY]) |=> deny_o[RQ_VERIFY]);   // R4

   AST_EXT_EXEC_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (lock_bits_i[2] && req_i[RQ_EXT_EXEC]) |=> deny_o[RQ_EXT_EXEC]);   // R5

   AST_FETCH_ALWAYS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      req_i[RQ_FETCH_INT] |=> grant_o[RQ_FETCH_INT]);   // R6

endmodule

// File: tb/code_lock_guard_test.sv
module code_lock_guard_test;

   localparam int CLK_PERIOD = 10;

   logic       clk = 1'b0;
   logic       rst_n;
   logic [2:0] lock_bits;
   logic       ea_pin;
   logic [4:0] req;
   logic [4:0] grant, deny;
   logic       ea_latched, ea_mismatch;

   int n_vec  = 0;
   int n_fail = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   code_lock_guard uut (
      .clk_i         (clk),
      .rst_ni        (rst_n),
      .lock_bits_i   (lock_bits),
      .ea_pin_i      (ea_pin),
      .req_i         (req),
      .grant_o       (grant),
      .deny_o        (deny),
      .ea_latched_o  (ea_latched),
      .ea_mismatch_o (ea_mismatch)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_vec++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
      end
   endtask

   function automatic int level_of(input logic [2:0] lb);
      case (lb)
         3'b000:  return 1;
         3'b001:  return 2;
         3'b011:  return 3;
         default: return 4;
      endcase
   endfunction

   function automatic logic [4:0] deny_mask(input int lvl);
      logic [4:0] m = '0;
      if (lvl >= 2) m[2:1] = 2'b11;
      if (lvl >= 3) m[3]   = 1'b1;
      if (lvl >= 4) m[4]   = 1'b1;
      return m;
   endfunction

   task automatic step(input logic [2:0] lb, input logic [4:0] rq, input logic pin);
      @(negedge clk);
      lock_bits = lb; req = rq; ea_pin = pin;
      @(posedge clk);
      #1;
   endtask

   initial begin
      #(CLK_PERIOD * 100000);
      n_fail++;
      $display("FAIL watchdog: actual running expected done");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

   initial begin
      rst_n = 1'b0; lock_bits = 3'b111; req = '1; ea_pin = 1'b1;
      repeat (2) @(posedge clk);
      #1;
      check("R8 grant in reset", grant, 0);
      check("R8 deny in reset", deny, 0);
      check("R8 mismatch in reset", ea_mismatch, 0);
      check("R8 latch follows pin 1", ea_latched, 1);
      step(3'b111, '1, 1'b0);
      check("R8 latch follows pin 0", ea_latched, 0);
      step(3'b000, '0, 1'b0);
      @(negedge clk); rst_n = 1'b1;

      // R1 R2 R3 R4 R5 R6 R7: every lock code against every request pattern
      for (int lb = 0; lb < 8; lb++) begin
         for (int rq = 0; rq < 32; rq++) begin
            logic [4:0] m;
            m = deny_mask(level_of(3'(lb)));
            step(3'(lb), 5'(rq), 1'b0);
            check($sformatf("R1/R2-R7 deny lb=%0d rq=%0d", lb, rq), deny, 5'(rq) & m);
            check($sformatf("R1/R2-R7 grant lb=%0d rq=%0d", lb, rq), grant, 5'(rq) & ~m);
         end
      end
      step(3'b000, '0, 1'b0);
      check("R7 quiet after idle grant", grant, 0);
      check("R7 quiet after idle deny", deny, 0);

      // R9 R11: capture pin=1 in reset while locked, then move the pin
      @(negedge clk); rst_n = 1'b0; lock_bits = 3'b001; ea_pin = 1'b1;
      @(posedge clk); #1;
      check("R8 latch capture", ea_latched, 1);
      @(negedge clk); rst_n = 1'b1;
      step(3'b001, '0, 1'b1);
      check("R11 no mismatch when equal", ea_mismatch, 0);
      step(3'b001, '0, 1'b0);
      check("R9 latch holds", ea_latched, 1);
      check("R11 mismatch raised", ea_mismatch, 1);
      step(3'b111, '0, 1'b0);
      check("R9 latch holds level4", ea_latched, 1);
      check("R11 mismatch level4", ea_mismatch, 1);
      // R10: back at level 1, latch tracks and flag clears
      step(3'b000, '0, 1'b0);
      check("R10 latch tracks 0", ea_latched, 0);
      check("R11 mismatch low at level1", ea_mismatch, 0);
      step(3'b000, '0, 1'b1);
      check("R10 latch tracks 1", ea_latched, 1);
      check("R11 mismatch stays low", ea_mismatch, 0);

      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
   end

endmodule